// File: doc/BRIEF.md
# Daisy-Chain Control Word Router

This block sits at the serial control input of one device in a chain of identical devices that share a host serial port. Each 16-bit control word arrives MSB first, one bit per clock. A one-cycle frame sync pulse marks the clock that carries the first bit. The word holds a 3-bit relative hop count. When the hop count is zero, this device claims the word. A claimed write updates one 8-bit register in the local control register file and raises a one-cycle write strobe. When the hop count is not zero, the block lowers it by one. It then re-sends the word on its serial output with a fresh frame sync, so that the next device in the chain, or the host at the end of the chain, receives it. Devices need no fixed identity: a word addressed with hop count k reaches the device k positions down the chain. With N devices, the counts 0 to N-1 are the valid ones.

Routing applies only to control words. While the `prog_mode` input is low, frames carry converter data, and this block neither claims nor forwards them.

The design has four parts. The receive deframer is an FSM with states RX_IDLE and RX_SHIFT. Frame sync moves it from RX_IDLE to RX_SHIFT. It returns to RX_IDLE after the sixteenth bit, or stays in RX_SHIFT on a new sync. A routing decision produces one of ROUTE_DROP, ROUTE_WRITE, ROUTE_READ or ROUTE_PASS. The transmit framer is an FSM with states TX_IDLE and TX_SEND. A load moves it from TX_IDLE to TX_SEND. It returns to TX_IDLE after sixteen bits, or stays in TX_SEND on a back-to-back load. The fourth part is the register file.

Top module: `hoprt_top`

## Requirements
- R1: After reset, every control register reads 0, and `sdo`, `sfs_out` and `wr_stb` are 0.
- R2: A frame is 16 bits, MSB first. The bit sampled in the same clock as `sfs_in` high is bit 15. Field layout: bit 15 is the write flag (1 = write), bits 14:12 are the hop count, bit 11 is spare, bits 10:8 are the register select and bits 7:0 are the data.
- R3: A frame with hop count 0 and write flag 1, received while `prog_mode` is high, loads bits 7:0 into the register chosen by bits 10:8. `wr_stb` is high for exactly one cycle, with `wr_sel` equal to the select, and appears in the clock after the one that sampled bit 0.
- R4: A frame with hop count 0 and write flag 0 changes no register, gives no strobe and is not forwarded.
- R5: A frame with hop count from 1 to 7 is re-sent on `sdo` with the hop count lowered by one and all other bits unchanged. Its bit 15 is sampled by a downstream device 16 clocks after this block sampled the incoming bit 15, in the clock in which `sfs_out` is high.
- R6: A frame with a non-zero hop count never changes a local register and never raises `wr_stb`.
- R7: While `prog_mode` is low at the clock that samples bit 0, the frame is neither claimed nor forwarded.
- R8: A frame sync that arrives before a frame is complete, including on the bit-0 clock, discards the partial frame and starts a new one.
- R9: Frames to forward that arrive back to back leave back to back, with `sfs_out` pulses exactly 16 clocks apart.
- R10: When nothing is being forwarded, `sdo` and `sfs_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | High when incoming frames are control words |
| sfs_in | input | 1 | Input frame sync, high in the clock of bit 15 |
| sdi | input | 1 | Serial data in, MSB first |
| sfs_out | output | 1 | Regenerated frame sync for the forwarded word |
| sdo | output | 1 | Serial data out toward the next device |
| wr_stb | output | 1 | One-cycle pulse when a local register is written |
| wr_sel | output | 3 | Register index of the last write |
| ctrl_regs | output | NUM_REGS*REG_W | Flattened register file, register i at bits i*REG_W upward |

## Verification
The hardest case to reach from the ports is a frame sync that cuts into a partial frame, above all one that lands on the bit-0 clock, where a completed frame and a restart compete in the same cycle. The bench reaches it with a driver that can stop after any number of bits. It cuts a forwardable frame after 7 bits and after 15 bits, then sends a full write frame at once, and checks that only the second frame takes effect. Back-to-back forwarding is exercised by three frames sent with no gap, so that the transmit framer reloads on the same clock in which it sends bit 0.

// File: rtl/hoprt_pkg.sv
package hoprt_pkg;
    localparam int FRAME_W  = 16;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int WR_POS   = 15;
    localparam int HOP_LSB  = 12;
    localparam int HOP_W    = 3;
    localparam int SEL_LSB  = 8;
    localparam int SEL_W    = 3;
    localparam int DATA_W   = 8;

    typedef enum logic {RX_IDLE, RX_SHIFT} rx_state_e;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
    typedef enum logic [1:0] {ROUTE_DROP, ROUTE_WRITE, ROUTE_READ, ROUTE_PASS} route_e;

    function automatic logic [HOP_W-1:0] hop_of(input logic [FRAME_W-1:0] w);
        return w[HOP_LSB +: HOP_W];
    endfunction

    function automatic logic [SEL_W-1:0] sel_of(input logic [FRAME_W-1:0] w);
        return w[SEL_LSB +: SEL_W];
    endfunction

    function automatic logic [DATA_W-1:0] data_of(input logic [FRAME_W-1:0] w);
        return w[DATA_W-1:0];
    endfunction

    function automatic logic [FRAME_W-1:0] hop_down(input logic [FRAME_W-1:0] w);
        logic [FRAME_W-1:0] r;
        r = w;
        r[HOP_LSB +: HOP_W] = w[HOP_LSB +: HOP_W] - HOP_W'(1);
        return r;
    endfunction
endpackage

// File: rtl/hoprt_rx.sv
module hoprt_rx
    import hoprt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sfs_in,
    input  logic               sdi,
    output logic               done,
    output logic [FRAME_W-1:0] word
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAME_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (sfs_in) state_d = RX_SHIFT;
            RX_SHIFT: begin
                if (sfs_in)             state_d = RX_SHIFT;
                else if (cnt_q == LAST) state_d = RX_IDLE;
                else                    state_d = RX_SHIFT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            sh_q <= {sh_q[FRAME_W-2:0], sdi};
            if (sfs_in)                    cnt_q <= CNT_W'(1);
            else if (state_q == RX_SHIFT)  cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        done = (state_q == RX_SHIFT) && (cnt_q == LAST) && !sfs_in;
        word = {sh_q[FRAME_W-2:0], sdi};
    end
endmodule

// File: rtl/hoprt_tx.sv
module hoprt_tx
    import hoprt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    output logic               sdo,
    output logic               sfs_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    tx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sr_q;
    logic               fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load) state_d = TX_SEND;
            TX_SEND: begin
                if (load)               state_d = TX_SEND;
                else if (cnt_q == LAST) state_d = TX_IDLE;
                else                    state_d = TX_SEND;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
            fs_q  <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            sr_q  <= load_word;
            fs_q  <= 1'b1;
        end else begin
            fs_q <= 1'b0;
            if (state_q == TX_SEND) begin
                cnt_q <= cnt_q + CNT_W'(1);
                sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        sdo     = sr_q[FRAME_W-1];
        sfs_out = fs_q;
    end
endmodule

// File: rtl/hoprt_regfile.sv
module hoprt_regfile
    import hoprt_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SEL_W-1:0]          sel,
    input  logic [REG_W-1:0]          wdata,
    output logic [NUM_REGS*REG_W-1:0] regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          r_q <= '0;
            else if (we && (sel == SEL_W'(i)))   r_q <= wdata;
        end
        assign regs[i*REG_W +: REG_W] = r_q;
    end
endmodule

// File: rtl/hoprt_top.sv
module hoprt_top
    import hoprt_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prog_mode,
    input  logic                      sfs_in,
    input  logic                      sdi,
    output logic                      sfs_out,
    output logic                      sdo,
    output logic                      wr_stb,
    output logic [SEL_W-1:0]          wr_sel,
    output logic [NUM_REGS*REG_W-1:0] ctrl_regs
);
    logic               rx_done;
    logic [FRAME_W-1:0] rx_word;
    route_e             route;
    logic               wr_stb_q;
    logic [SEL_W-1:0]   wr_sel_q;

    hoprt_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sfs_in(sfs_in), .sdi(sdi),
        .done(rx_done), .word(rx_word)
    );

    always_comb begin
        if (!rx_done || !prog_mode)      route = ROUTE_DROP;
        else if (hop_of(rx_word) != '0)  route = ROUTE_PASS;
        else if (rx_word[WR_POS])        route = ROUTE_WRITE;
        else                             route = ROUTE_READ;
    end

    hoprt_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(route == ROUTE_PASS), .load_word(hop_down(rx_word)),
        .sdo(sdo), .sfs_out(sfs_out)
    );

    hoprt_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(route == ROUTE_WRITE), .sel(sel_of(rx_word)),
        .wdata(REG_W'(data_of(rx_word))), .regs(ctrl_regs)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb_q <= 1'b0;
            wr_sel_q <= '0;
        end else begin
            wr_stb_q <= (route == ROUTE_WRITE);
            if (route == ROUTE_WRITE) wr_sel_q <= sel_of(rx_word);
        end
    end

    always_comb begin
        wr_stb = wr_stb_q;
        wr_sel = wr_sel_q;
    end
endmodule

// File: rtl/hoprt_chk.sv
module hoprt_chk
    import hoprt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               prog_mode,
    input logic               sfs_out,
    input logic               wr_stb,
    input logic               rx_done,
    input logic [FRAME_W-1:0] rx_word
);
    assert_write_needs_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(prog_mode));

    assert_pass_needs_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sfs_out |-> $past(prog_mode));

    assert_claim_or_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfs_out && wr_stb));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_single_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sfs_out |=> !sfs_out);

    assert_nonzero_hop_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && prog_mode && (rx_word[HOP_LSB +: HOP_W] != '0)) |=> sfs_out);
endmodule

bind hoprt_top hoprt_chk chk_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sfs_out(sfs_out),
    .wr_stb(wr_stb), .rx_done(rx_done), .rx_word(rx_word)
);

// File: tb/hoprt_top_tb_top.sv
module hoprt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b1;
    logic        sfs_in = 1'b0;
    logic        sdi = 1'b0;
    logic        sfs_out, sdo, wr_stb;
    logic [2:0]  wr_sel;
    logic [63:0] ctrl_regs;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_start = 0;
    int mon_n = 0;
    logic [15:0] mon_word [0:127];
    int          mon_cyc  [0:127];
    int stb_n = 0;
    int stb_cyc = 0;
    logic [2:0] stb_sel = '0;
    logic [7:0] model [0:7];
    bit done_flag = 0;

    hoprt_top dut_i (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sfs_in(sfs_in), .sdi(sdi),
        .sfs_out(sfs_out), .sdo(sdo), .wr_stb(wr_stb), .wr_sel(wr_sel), .ctrl_regs(ctrl_regs)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // output frame monitor
    initial forever begin
        @(negedge clk);
        if (rst_n && sfs_out) begin
            logic [15:0] w;
            int st;
            st = cyc;
            w = '0;
            w[15] = sdo;
            for (int i = 14; i >= 0; i--) begin
                @(negedge clk);
                w[i] = sdo;
            end
            mon_word[mon_n] = w;
            mon_cyc[mon_n] = st;
            mon_n++;
        end
    end

    initial forever begin
        @(negedge clk);
        if (rst_n && wr_stb) begin
            stb_n++;
            stb_cyc = cyc;
            stb_sel = wr_sel;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) last_start = cyc + 1;
            sfs_in = (i == 0);
            sdi = w[15-i];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sfs_in = 1'b0;
            sdi = 1'b0;
        end
    endtask

    function automatic logic [15:0] mk(input bit wr, input int hop, input bit sp,
                                       input int sel, input logic [7:0] d);
        return {wr, 3'(hop), sp, 3'(sel), d};
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++)
            check(ctrl_regs[i*8 +: 8] == model[i], req, $sformatf("reg%0d", i),
                  ctrl_regs[i*8 +: 8], model[i]);
    endtask

    initial begin
        #1500000;
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ctrl_regs == '0, "R1", "regs", int'(ctrl_regs[31:0]), 0);
        check(sdo == 0 && sfs_out == 0 && wr_stb == 0, "R1", "outputs",
              {sdo, sfs_out, wr_stb}, 0);
        rst_n = 1'b1;
        idle(3);

        // R3 and R2: write every register through hop count 0
        for (int s = 0; s < 8; s++) begin
            logic [7:0] d;
            int sn, mn;
            d = 8'(s * 8'h11) ^ 8'hA5;
            sn = stb_n;
            mn = mon_n;
            send_bits(mk(1, 0, s[0], s, d), 16);
            idle(20);
            model[s] = d;
            check_regs("R3");
            check(stb_n == sn + 1, "R3", "strobe count", stb_n - sn, 1);
            check(stb_sel == 3'(s), "R3", "wr_sel", stb_sel, s);
            check(stb_cyc == last_start + 15, "R3", "strobe cycle", stb_cyc, last_start + 15);
            check(mon_n == mn, "R3", "no forward", mon_n - mn, 0);
            check(sdo == 0 && sfs_out == 0, "R10", "idle outputs", {sdo, sfs_out}, 0);
        end

        // R5 R6 R2: forward every non-zero hop count with several bit patterns
        for (int h = 1; h < 8; h++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0] d;
                    logic [15:0] w, e;
                    int sn, mn;
                    d = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'(h * 37 + wr);
                    w = mk(wr[0], h, p[0], h + p, d);
                    e = mk(wr[0], h - 1, p[0], h + p, d);
                    sn = stb_n;
                    mn = mon_n;
                    send_bits(w, 16);
                    idle(20);
                    check(mon_n == mn + 1, "R5", "frames out", mon_n - mn, 1);
                    check(mon_word[mn] == e, "R5", "forwarded word", mon_word[mn], e);
                    check(mon_cyc[mn] == last_start + 15, "R5", "latency",
                          mon_cyc[mn], last_start + 15);
                    check(stb_n == sn, "R6", "no strobe", stb_n - sn, 0);
                end
            end
            check_regs("R6");
            check(sdo == 0 && sfs_out == 0, "R10", "idle after forward", {sdo, sfs_out}, 0);
        end

        // R4: claimed read frame
        begin
            int sn, mn;
            sn = stb_n;
            mn = mon_n;
            send_bits(mk(0, 0, 1, 2, 8'h5A), 16);
            idle(20);
            check_regs("R4");
            check(stb_n == sn, "R4", "no strobe", stb_n - sn, 0);
            check(mon_n == mn, "R4", "no forward", mon_n - mn, 0);
        end

        // R7: data frames while not in program mode
        begin
            int sn, mn;
            @(negedge clk);
            prog_mode = 1'b0;
            sn = stb_n;
            mn = mon_n;
            send_bits(mk(1, 0, 0, 4, 8'h77), 16);
            send_bits(mk(1, 3, 0, 4, 8'h66), 16);
            idle(24);
            check_regs("R7");
            check(stb_n == sn, "R7", "no strobe", stb_n - sn, 0);
            check(mon_n == mn, "R7", "no forward", mon_n - mn, 0);
            prog_mode = 1'b1;
            idle(2);
        end

        // R8: sync restarts a partial frame, including on the bit-0 clock
        for (int k = 0; k < 2; k++) begin
            int cut, sn, mn;
            logic [7:0] d;
            cut = (k == 0) ? 7 : 15;
            d = (k == 0) ? 8'h3C : 8'hC3;
            sn = stb_n;
            mn = mon_n;
            send_bits(mk(1, 2, 1, 1, 8'h99), cut);
            send_bits(mk(1, 0, 0, 5, d), 16);
            idle(36);
            model[5] = d;
            check_regs("R8");
            check(stb_n == sn + 1, "R8", "one strobe", stb_n - sn, 1);
            check(mon_n == mn, "R8", "partial not forwarded", mon_n - mn, 0);
        end

        // R9: back-to-back forwards
        begin
            int mn;
            int st [0:2];
            logic [15:0] e [0:2];
            int hops [0:2];
            hops[0] = 1; hops[1] = 2; hops[2] = 7;
            mn = mon_n;
            for (int j = 0; j < 3; j++) begin
                send_bits(mk(j[0], hops[j], 0, j, 8'(8'h40 + j)), 16);
                st[j] = last_start;
                e[j] = mk(j[0], hops[j] - 1, 0, j, 8'(8'h40 + j));
            end
            idle(40);
            check(mon_n == mn + 3, "R9", "frames out", mon_n - mn, 3);
            for (int j = 0; j < 3; j++) begin
                check(mon_word[mn + j] == e[j], "R9", "word", mon_word[mn + j], e[j]);
                check(mon_cyc[mn + j] == st[j] + 15, "R9", "start", mon_cyc[mn + j], st[j] + 15);
            end
            check(sdo == 0 && sfs_out == 0, "R10", "idle after burst", {sdo, sfs_out}, 0);
            check_regs("R9");
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule